// File: doc/BRIEF.md
# Most-Significant-First Two-Way Minimum Selector

This block takes two unsigned operands of W bits, each with its own valid flag, and returns the smaller of them, a flag naming the winning side, and an output valid flag. It is meant to be one node of a find-minimum tree, for example one level of a scheduler that has to pick the lowest priority tag among many eligible entries. Several nodes feed one another, and the winner flag is stored so that the tree can trace the winning leaf.

The operand bits are split into groups of G bits, counted from the most significant end. The last group, at the least significant end, may be shorter when W is not a multiple of G. Each group compares its own slice of A and B and reports two facts: whether the slices are equal, and whether the A slice is smaller. A decision chain runs from the top group down to the bottom group. This is a carry chain turned upside down. At each group the chain picks between two results prepared in advance. If a higher group has already found a difference, the inherited verdict is used. Otherwise the group's own local verdict is used. The same choice steers the multiplexer that places that group's output bits. An output group therefore never depends on the input bits below it.

The input case is classified into one of four cases: CASE_NONE, CASE_A_ONLY, CASE_B_ONLY or CASE_BOTH. A unique case statement chooses the next output for each case. There are no transitions that carry over from one cycle to the next, because each cycle is classified again. A single register stage holds the result, so results appear one clock after the inputs.

Top module: `msbf_min_select`

## Requirements
- R1: When both inputs are valid, min_data equals the numerically smaller of a_data and b_data, and min_vld is 1.
- R2: When both inputs are valid, pick_b is 1 exactly when b_data is strictly smaller than a_data.
- R3: When both inputs are valid and a_data equals b_data, pick_b is 0.
- R4: When only a_vld is set, min_data equals a_data, pick_b is 0 and min_vld is 1, whatever b_data holds.
- R5: When only b_vld is set, min_data equals b_data, pick_b is 1 and min_vld is 1, whatever a_data holds.
- R6: When neither input is valid, min_vld, pick_b and min_data are all 0.
- R7: While rst_n is low, all outputs are 0. Every result appears on the outputs at the first rising clock edge after its inputs were presented.
- R8: The result is correct when W is not a multiple of G. The least significant group then holds the remaining W mod G bits.
- R9: Every group's select agrees with the final winner once a higher group has found a difference. When a result is valid, min_data is the whole operand named by pick_b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_data | input | W | Operand A, unsigned |
| a_vld | input | 1 | Operand A takes part |
| b_data | input | W | Operand B, unsigned |
| b_vld | input | 1 | Operand B takes part |
| min_data | output | W | Registered smaller operand |
| pick_b | output | 1 | Registered winner flag, 1 means B |
| min_vld | output | 1 | Registered result valid |

## Verification
Every result (min_data, pick_b, min_vld) is due exactly one rising edge after its inputs are applied. The bench drives each input pair on a falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. It never samples in the same cycle it drives. The reset state is read while rst_n is still held low, before any operand is driven.

// File: rtl/msbf_pkg.sv
package msbf_pkg;

    // Verdict of one bit group, computed from that group's slices alone
    typedef struct packed {
        logic eq;    // slices identical
        logic a_lt;  // A slice smaller than B slice
    } grp_res_t;

    // Which operands take part this cycle
    typedef enum logic [1:0] {
        CASE_NONE   = 2'b00,
        CASE_A_ONLY = 2'b01,
        CASE_B_ONLY = 2'b10,
        CASE_BOTH   = 2'b11
    } sel_case_t;

endpackage

// File: rtl/msbf_grp_cmp.sv
module msbf_grp_cmp
    import msbf_pkg::*;
#(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a_grp,
    input  logic [GW-1:0] b_grp,
    output grp_res_t      res
);

    always_comb begin
        res.eq   = (a_grp == b_grp);
        res.a_lt = (a_grp < b_grp);
    end

endmodule

// File: rtl/msbf_grp_mux.sv
module msbf_grp_mux #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a_grp,
    input  logic [GW-1:0] b_grp,
    input  logic          take_b,
    output logic [GW-1:0] y
);

    always_comb y = take_b ? b_grp : a_grp;

endmodule

// File: rtl/msbf_decide_chain.sv
module msbf_decide_chain
    import msbf_pkg::*;
#(
    parameter int NG = 6
) (
    input  grp_res_t [NG-1:0] res,      // index 0 = most significant group
    output logic [NG-1:0]     take_b,   // per-group select
    output logic [NG-1:0]     settled,  // a higher group already differed
    output logic              final_b
);

    logic [NG:0] found;
    logic [NG:0] b_won;

    assign found[0] = 1'b0;
    assign b_won[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < NG; k++) begin : g_link
            logic local_b;
            // alternative used while all higher groups are equal
            assign local_b    = !res[k].eq && !res[k].a_lt;
            // inherited verdict wins once a difference is known
            assign take_b[k]  = found[k] ? b_won[k] : local_b;
            assign found[k+1] = found[k] | !res[k].eq;
            assign b_won[k+1] = take_b[k];
        end
    endgenerate

    assign settled = found[NG-1:0];
    assign final_b = b_won[NG];

endmodule

// File: rtl/msbf_min_select.sv
module msbf_min_select
    import msbf_pkg::*;
#(
    parameter int W = 24,
    parameter int G = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_data,
    input  logic         a_vld,
    input  logic [W-1:0] b_data,
    input  logic         b_vld,
    output logic [W-1:0] min_data,
    output logic         pick_b,
    output logic         min_vld
);

    localparam int NG = (W + G - 1) / G;

    grp_res_t [NG-1:0] grp_res;
    logic [NG-1:0]     grp_take_b;
    logic [NG-1:0]     grp_settled;
    logic              cmp_b;
    logic [W-1:0]      cmp_min;

    genvar k;
    generate
        for (k = 0; k < NG; k++) begin : g_grp
            localparam int HI = W - 1 - k * G;
            localparam int LO = (HI - G + 1 > 0) ? HI - G + 1 : 0;
            localparam int GW = HI - LO + 1;

            msbf_grp_cmp #(.GW(GW)) u_cmp (
                .a_grp (a_data[HI:LO]),
                .b_grp (b_data[HI:LO]),
                .res   (grp_res[k])
            );

            msbf_grp_mux #(.GW(GW)) u_mux (
                .a_grp  (a_data[HI:LO]),
                .b_grp  (b_data[HI:LO]),
                .take_b (grp_take_b[k]),
                .y      (cmp_min[HI:LO])
            );

            // R9: a group below a decided one must follow the final winner
            assert_grp_agrees_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (a_vld && b_vld && grp_settled[k]) |-> (grp_take_b[k] == cmp_b));
        end
    endgenerate

    msbf_decide_chain #(.NG(NG)) u_chain (
        .res     (grp_res),
        .take_b  (grp_take_b),
        .settled (grp_settled),
        .final_b (cmp_b)
    );

    sel_case_t    in_case;
    logic [W-1:0] nxt_min;
    logic         nxt_pick_b;
    logic         nxt_vld;

    always_comb begin
        in_case    = sel_case_t'({b_vld, a_vld});
        nxt_min    = '0;
        nxt_pick_b = 1'b0;
        nxt_vld    = 1'b0;
        unique case (in_case)
            CASE_NONE: begin
                nxt_vld = 1'b0;
            end
            CASE_A_ONLY: begin
                nxt_min = a_data;
                nxt_vld = 1'b1;
            end
            CASE_B_ONLY: begin
                nxt_min    = b_data;
                nxt_pick_b = 1'b1;
                nxt_vld    = 1'b1;
            end
            CASE_BOTH: begin
                nxt_min    = cmp_min;
                nxt_pick_b = cmp_b;
                nxt_vld    = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_data <= '0;
            pick_b   <= 1'b0;
            min_vld  <= 1'b0;
        end else begin
            min_data <= nxt_min;
            pick_b   <= nxt_pick_b;
            min_vld  <= nxt_vld;
        end
    end

    assert_min_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (a_vld && b_vld) |=> (min_vld && min_data <= $past(a_data) && min_data <= $past(b_data)));

    assert_tie_keeps_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_vld && b_vld && a_data == b_data) |=> !pick_b);

    assert_a_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_vld && !b_vld) |=> (min_vld && !pick_b && min_data == $past(a_data)));

    assert_b_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_vld && b_vld) |=> (min_vld && pick_b && min_data == $past(b_data)));

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_vld && !b_vld) |=> (!min_vld && !pick_b));

endmodule

// File: tb/msbf_min_select_tb.sv
module msbf_min_select_tb_top;

    localparam int W = 6;
    localparam int G = 4;   // R8: 6 bits -> groups of 4 and 2

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_data = '0;
    logic [W-1:0] b_data = '0;
    logic         a_vld = 1'b0;
    logic         b_vld = 1'b0;
    logic [W-1:0] min_data;
    logic         pick_b;
    logic         min_vld;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    msbf_min_select #(.W(W), .G(G)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_data   (a_data),
        .a_vld    (a_vld),
        .b_data   (b_data),
        .b_vld    (b_vld),
        .min_data (min_data),
        .pick_b   (pick_b),
        .min_vld  (min_vld)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive on a falling edge, read one capturing edge later
    task automatic apply(input int av, input int bv, input logic va, input logic vb);
        @(negedge clk);
        a_data = W'(av);
        b_data = W'(bv);
        a_vld  = va;
        b_vld  = vb;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(min_vld == 1'b0, "R7 vld in reset", int'(min_vld), 0);
        chk(pick_b == 1'b0, "R7 pick in reset", int'(pick_b), 0);
        chk(min_data == '0, "R7 data in reset", int'(min_data), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R8 R9 R7: exhaustive pairs
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                int exp_min;
                int exp_b;
                exp_min = (b < a) ? b : a;
                exp_b   = (b < a) ? 1 : 0;
                apply(a, b, 1'b1, 1'b1);
                chk(min_vld == 1'b1, "R1 vld", int'(min_vld), 1);
                chk(int'(min_data) == exp_min, "R1 R8 min", int'(min_data), exp_min);
                chk(int'(pick_b) == exp_b, (a == b) ? "R3 tie" : "R2 pick", int'(pick_b), exp_b);
                chk(int'(min_data) == (pick_b ? b : a), "R9 whole word", int'(min_data),
                    pick_b ? b : a);
            end
        end

        // R4 R5 R6: single and no valid operand
        for (int a = 0; a < (1 << W); a++) begin
            int other;
            other = (a * 37 + 5) % (1 << W);
            apply(a, other, 1'b1, 1'b0);
            chk(min_vld && int'(min_data) == a, "R4 a pass", int'(min_data), a);
            chk(pick_b == 1'b0, "R4 pick", int'(pick_b), 0);
            apply(other, a, 1'b0, 1'b1);
            chk(min_vld && int'(min_data) == a, "R5 b pass", int'(min_data), a);
            chk(pick_b == 1'b1, "R5 pick", int'(pick_b), 1);
            apply(a, other, 1'b0, 1'b0);
            chk(min_vld == 1'b0, "R6 vld", int'(min_vld), 0);
            chk(pick_b == 1'b0 && min_data == '0, "R6 zero", int'(min_data), 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule